// File: doc/BRIEF.md
# Registered Tri-Port Bus Exchanger

This block sits between a processor-side data port A and two memory-bank ports, B1 (even bank) and B2 (odd bank). Four data registers, all clocked by one rising edge, carry words in each direction: A into B1, A into B2, B1 back toward A and B2 back toward A. Each register loads only in a cycle where its own active-low load enable is low; otherwise it keeps its word. Because the two outbound registers load independently, one word on A can go to either bank or to both.

The direction controls are registered as well. The return-path select, the A-side output enable and the shared output enable for both B ports are captured at the clock edge, so a change of source or direction takes effect only at an edge. Each bidirectional port is shown as a separate input, output and enable; pad keepers and drive strength are outside the block.

Top module: `bus_exchanger`

## Requirements
- R1: A synchronous active-high reset clears all four data registers to zero, sets the registered select to 0 and sets both registered output enables to disabled, so that a_oe and b_oe read 0 after reset.
- R2: When ld_a2b1_n is 0 at a rising edge, the A-to-B1 register takes a_in, and b1_out shows that word after the edge.
- R3: When ld_a2b2_n is 0 at a rising edge, the A-to-B2 register takes a_in. With both A-side load enables low in the same cycle, both registers take the same word.
- R4: When ld_b12a_n or ld_b22a_n is 0 at a rising edge, the B1-to-A or B2-to-A register takes b1_in or b2_in.
- R5: A register whose load enable is 1 at an edge keeps its word, and its port goes on showing the earlier value.
- R6: a_out shows the B1-to-A register when the select registered at the last edge was 1, and the B2-to-A register when it was 0. A change of sel_b1 alters a_out only after the next edge.
- R7: a_oe is 1 exactly when a_oe_n was 0 at the previous rising edge.
- R8: b_oe drives both B ports and is 1 exactly when b_oe_n was 0 at the previous rising edge. Disabling it lets the B-to-A registers be loaded from the B ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_a2b1_n | input | 1 | Active-low load enable, A-to-B1 register |
| ld_a2b2_n | input | 1 | Active-low load enable, A-to-B2 register |
| ld_b12a_n | input | 1 | Active-low load enable, B1-to-A register |
| ld_b22a_n | input | 1 | Active-low load enable, B2-to-A register |
| sel_b1 | input | 1 | Return-path select, 1 = B1, 0 = B2 (registered) |
| a_oe_n | input | 1 | Active-low A-port output enable (registered) |
| b_oe_n | input | 1 | Active-low shared B-ports output enable (registered) |
| a_in | input | 12 | Port A input word |
| a_out | output | 12 | Port A output word |
| a_oe | output | 1 | Port A drive enable |
| b1_in | input | 12 | Port B1 input word |
| b1_out | output | 12 | Port B1 output word |
| b2_in | input | 12 | Port B2 input word |
| b2_out | output | 12 | Port B2 output word |
| b_oe | output | 1 | Drive enable for both B ports |

## Verification
Every output of this block lies one register stage from the inputs that feed it. A load, a select change or an enable change shows at the ports one edge after it is sampled, and the bench compares all outputs against its model one cycle after each stimulus. Inputs are driven on the falling edge and outputs are sampled just before the next falling edge, well after the rising edge they depend on. Directed cases cover dual loads, holds, select flips between cycles and the one-clock enable lag; random cycles then mix every control.

// File: rtl/bus_exchanger_pkg.sv
package bus_exchanger_pkg;
  typedef struct packed {
    logic sel_b1;
    logic a_oe;
    logic b_oe;
  } xchg_ctrl_t;
endpackage

// File: rtl/xchg_data_reg.sv
module xchg_data_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (!ld_n) q <= d;
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(ld_n) && !$past(rst) |-> $stable(q)); // R5
  AST_LOAD_TAKES_D: assert property (@(posedge clk) disable iff (rst)
    !$past(ld_n) && !$past(rst) |-> q == $past(d)); // R2
endmodule

// File: rtl/xchg_ctrl_reg.sv
module xchg_ctrl_reg
  import bus_exchanger_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sel_b1,
  input  logic       a_oe_n,
  input  logic       b_oe_n,
  output xchg_ctrl_t ctrl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '{sel_b1: 1'b0, a_oe: 1'b0, b_oe: 1'b0};
    end else begin
      ctrl.sel_b1 <= sel_b1;
      ctrl.a_oe   <= !a_oe_n;
      ctrl.b_oe   <= !b_oe_n;
    end
  end

  AST_A_OE_LAG: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ctrl.a_oe == !$past(a_oe_n)); // R7
  AST_B_OE_LAG: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ctrl.b_oe == !$past(b_oe_n)); // R8
endmodule

// File: rtl/bus_exchanger.sv
module bus_exchanger
  import bus_exchanger_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_a2b1_n,
  input  logic             ld_a2b2_n,
  input  logic             ld_b12a_n,
  input  logic             ld_b22a_n,
  input  logic             sel_b1,
  input  logic             a_oe_n,
  input  logic             b_oe_n,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b1_in,
  output logic [WIDTH-1:0] b1_out,
  input  logic [WIDTH-1:0] b2_in,
  output logic [WIDTH-1:0] b2_out,
  output logic             b_oe
);
  localparam int NREG = 4;

  logic [NREG-1:0]  ld_n;
  logic [WIDTH-1:0] d   [NREG];
  logic [WIDTH-1:0] q   [NREG];
  xchg_ctrl_t       ctrl;

  // index: 0 A->B1, 1 A->B2, 2 B1->A, 3 B2->A
  assign ld_n = {ld_b22a_n, ld_b12a_n, ld_a2b2_n, ld_a2b1_n};
  assign d[0] = a_in;
  assign d[1] = a_in;
  assign d[2] = b1_in;
  assign d[3] = b2_in;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    xchg_data_reg #(.W(WIDTH)) u_reg (
      .clk (clk),
      .rst (rst),
      .ld_n(ld_n[i]),
      .d   (d[i]),
      .q   (q[i])
    );
  end

  xchg_ctrl_reg u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .sel_b1(sel_b1),
    .a_oe_n(a_oe_n),
    .b_oe_n(b_oe_n),
    .ctrl  (ctrl)
  );

  assign a_out  = ctrl.sel_b1 ? q[2] : q[3];
  assign a_oe   = ctrl.a_oe;
  assign b1_out = q[0];
  assign b2_out = q[1];
  assign b_oe   = ctrl.b_oe;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (a_out == '0 && b1_out == '0 && b2_out == '0 && !a_oe && !b_oe)); // R1
  AST_DUAL_LOAD: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(ld_a2b1_n) && !$past(ld_a2b2_n) |-> b1_out == b2_out); // R3
  AST_SEL_B1_PATH: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(sel_b1) && !$past(ld_b12a_n) |-> a_out == $past(b1_in)); // R6
  AST_SEL_B2_PATH: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(sel_b1) && !$past(ld_b22a_n) |-> a_out == $past(b2_in)); // R4
endmodule

// File: tb/test_bus_exchanger.sv
module test_bus_exchanger;
  localparam int W = 12;
  logic clk = 0, rst = 1;
  logic ld_a2b1_n = 1, ld_a2b2_n = 1, ld_b12a_n = 1, ld_b22a_n = 1;
  logic sel_b1 = 0, a_oe_n = 1, b_oe_n = 1;
  logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
  logic [W-1:0] a_out, b1_out, b2_out;
  logic a_oe, b_oe;

  int n_cmp = 0, n_bad = 0;
  logic [W-1:0] m_b1, m_b2, m_r1, m_r2;
  logic m_sel, m_aoe, m_boe;

  always #2 clk = ~clk;

  bus_exchanger #(.WIDTH(W)) i_bus_exchanger (
    .clk(clk), .rst(rst), .ld_a2b1_n(ld_a2b1_n), .ld_a2b2_n(ld_a2b2_n),
    .ld_b12a_n(ld_b12a_n), .ld_b22a_n(ld_b22a_n), .sel_b1(sel_b1),
    .a_oe_n(a_oe_n), .b_oe_n(b_oe_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b1_in(b1_in), .b1_out(b1_out), .b2_in(b2_in), .b2_out(b2_out), .b_oe(b_oe)
  );

  function automatic logic [W-1:0] exp_a(input logic s, input logic [W-1:0] r1, input logic [W-1:0] r2);
    return s ? r1 : r2;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at falling edge, update model, wait for rising edge, check before next fall
  task automatic step(input logic l1, l2, l3, l4, s, ao, bo,
                      input logic [W-1:0] a, b1, b2, input string req);
    @(negedge clk);
    ld_a2b1_n = l1; ld_a2b2_n = l2; ld_b12a_n = l3; ld_b22a_n = l4;
    sel_b1 = s; a_oe_n = ao; b_oe_n = bo; a_in = a; b1_in = b1; b2_in = b2;
    if (!l1) m_b1 = a;
    if (!l2) m_b2 = a;
    if (!l3) m_r1 = b1;
    if (!l4) m_r2 = b2;
    m_sel = s; m_aoe = !ao; m_boe = !bo;
    @(posedge clk); #1;
    chk({req, " R2 b1_out"}, b1_out, m_b1);
    chk({req, " R3 b2_out"}, b2_out, m_b2);
    chk({req, " R6 a_out"}, a_out, exp_a(m_sel, m_r1, m_r2));
    chk({req, " R7 a_oe"}, {11'd0, a_oe}, {11'd0, m_aoe});
    chk({req, " R8 b_oe"}, {11'd0, b_oe}, {11'd0, m_boe});
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    m_b1 = '0; m_b2 = '0; m_r1 = '0; m_r2 = '0; m_sel = 0; m_aoe = 0; m_boe = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 b1_out", b1_out, '0);
    chk("R1 b2_out", b2_out, '0);
    chk("R1 a_out", a_out, '0);
    chk("R1 oe", {10'd0, a_oe, b_oe}, '0);
    @(negedge clk); rst = 0;
    // R3 both B registers at once
    step(0,0,1,1, 0,1,0, 12'hA5C, 12'h111, 12'h222, "R3 dual");
    // R5 holds
    step(1,1,1,1, 0,1,0, 12'h333, 12'h444, 12'h555, "R5 hold");
    // R2 only B1
    step(0,1,1,1, 0,1,0, 12'h0F0, 12'h000, 12'h000, "R2 single");
    // R4/R8 load returns with B disabled
    step(1,1,0,0, 1,0,1, 12'h000, 12'hB11, 12'hB22, "R4 load");
    // R6 select switching between cycles
    step(1,1,1,1, 0,0,1, 12'h000, 12'h777, 12'h888, "R6 sel0");
    step(1,1,1,1, 1,0,1, 12'h000, 12'h777, 12'h888, "R6 sel1");
    // R7 enable lag: check value before edge is still old
    @(negedge clk); a_oe_n = 1; #1;
    chk("R7 before edge", {11'd0, a_oe}, 12'd1);
    step(1,1,1,1, 1,1,1, 12'h000, 12'h000, 12'h000, "R7 off");
    // R5 return register holds with enable high
    step(1,1,1,0, 1,0,1, 12'h000, 12'hFFF, 12'h999, "R5 ret");
    for (int i = 0; i < 300; i++) begin
      logic [6:0] c = 7'($urandom);
      step(c[0], c[1], c[2], c[3], c[4], c[5], c[6],
           W'($urandom), W'($urandom), W'($urandom), "rand");
    end
    // R1 reset mid-run
    @(negedge clk); rst = 1;
    @(posedge clk); #1;
    chk("R1 re-reset", {a_out, 1'b0} ^ {b1_out, a_oe} ^ {b2_out, b_oe}, '0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule